// File: doc/BRIEF.md
# Channel Output Power Sequencer

This block brings each of several analog output channels up and down in a safe order. For every channel it drives three enables: one for the channel's internal circuits, one for its DC-DC converter and one for the output stage. A level-sensitive request bit per channel asks for that channel to be powered down (1) or powered up (0). The block compares each request with the channel's present state and runs the matching sequence.

Power-up has two phases. First the internal enable and the converter enable rise together. The block then counts a fixed settle time in ticks of an external microsecond strobe. Only after that does the output enable rise. Power-down drops all three enables in one clock edge.

Only one channel can be in its settle window at a time. When several channels need service, the lowest index is served first. A channel in its settle window can be aborted at once by asking for power-down. A status vector shows which channels are fully powered down.

Top module: `chan_pwr_seq`

## Requirements
- R1: After reset every enable output is 0, every `pd_status` bit is 1 and `busy` is 0.
- R2: A 0 on `pd_req[i]` while channel i is powered down and the block is idle sets `core_en[i]` and `boost_en[i]` at the next clock edge, with `out_en[i]` still 0 and `busy` high.
- R3: `out_en[i]` rises on the clock edge that samples the (SETTLE_TICKS+1)-th `us_tick` counted after the edge that started phase one. A tick sampled on that starting edge, or while no channel settles, is not counted. Cycles without a tick do not advance the count.
- R4: A 1 on `pd_req[i]` for a fully powered channel clears `core_en[i]`, `boost_en[i]` and `out_en[i]` together at the next clock edge, and sets `pd_status[i]`.
- R5: A request that already matches the channel's state changes no output. This covers 1 on a powered-down channel and 0 on a powered channel.
- R6: At most one channel is in its settle window at any time. When several channels need service in the same cycle, the lowest index is served first.
- R7: While `busy` is high, requests from channels other than the settling one are held back: their enables and status stay unchanged until the settle ends.
- R8: A 1 on `pd_req[i]` while channel i is settling clears all three of its enables at the next edge, and `busy` falls.
- R9: `pd_status[i]` is 1 exactly when channel i has all three enables cleared. It is 0 both in the settle window and when the channel is fully on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | NUM_CH | Per-channel request: 1 asks for power-down, 0 asks for power-up |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| core_en | output | NUM_CH | Internal circuit enable per channel |
| boost_en | output | NUM_CH | DC-DC converter enable per channel |
| out_en | output | NUM_CH | Output stage enable per channel |
| pd_status | output | NUM_CH | 1 while the channel is fully powered down |
| busy | output | 1 | High while a channel is inside its settle window |

## Verification
Some properties are checked by assertions on every cycle:
- the output enable only rises on a tick and after both phase-one enables were already high;
- a power-down, or an abort during settle, leaves no enable set one edge later;
- at most one channel is ever settling;
- channels that are not settling stay frozen while `busy` is high;
- the settle counter stays within its bound.

Other behaviour needs the directed scenarios. These cover the exact tick count before the output stage turns on, and the way ticks are ignored on the starting edge and between gaps. They also cover ascending service order when requests arrive together, and the order in which held-back requests drain after an abort.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   // Per-channel sequencing state
   typedef enum logic [1:0] {
      CH_OFF    = 2'd0,
      CH_SETTLE = 2'd1,
      CH_ON     = 2'd2
   } ch_state_e;

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
   parameter int SETTLE_TICKS = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   input  logic us_tick,
   output logic done
);

   localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_TICKS);

   logic [CNT_W-1:0] cnt;

   generate
      if (SETTLE_TICKS < 1) begin : g_bad_ticks
         $error("pwr_seq_timer: SETTLE_TICKS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (start)
         cnt <= '0;
      else if (run && us_tick && cnt != LAST)
         cnt <= cnt + 1'b1;
   end

   assign done = run && us_tick && (cnt == LAST);

   // R3
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

   // R3
   count_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !us_tick) |=> $stable(cnt));

endmodule

// File: rtl/pwr_seq_arb.sv
module pwr_seq_arb #(
   parameter int NUM_CH = 4
) (
   input  logic [NUM_CH-1:0] eligible,
   output logic [NUM_CH-1:0] grant
);

   logic [NUM_CH:0] seen;

   assign seen[0] = 1'b0;

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_prio
         assign seen[g+1] = seen[g] | eligible[g];
         assign grant[g]  = eligible[g] & ~seen[g];
      end
   endgenerate

endmodule

// File: rtl/pwr_seq_chan.sv
module pwr_seq_chan
   import pwr_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      grant,
   input  logic      settle_done,
   output ch_state_e state,
   output logic      core_en,
   output logic      boost_en,
   output logic      out_en
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         state <= CH_OFF;
      else if (grant)
         state <= (state == CH_OFF) ? CH_SETTLE : CH_OFF;
      else if (state == CH_SETTLE && settle_done)
         state <= CH_ON;
   end

   assign core_en  = (state != CH_OFF);
   assign boost_en = (state != CH_OFF);
   assign out_en   = (state == CH_ON);

   // R4
   down_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && state != CH_OFF) |=> (!core_en && !boost_en && !out_en));

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant && state != CH_SETTLE) |=> $stable(state));

   // R2
   out_after_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_en) |-> ($past(core_en) && $past(boost_en)));

endmodule

// File: rtl/chan_pwr_seq.sv
module chan_pwr_seq
   import pwr_seq_pkg::*;
#(
   parameter int NUM_CH       = 4,
   parameter int SETTLE_TICKS = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pd_req,
   input  logic              us_tick,
   output logic [NUM_CH-1:0] core_en,
   output logic [NUM_CH-1:0] boost_en,
   output logic [NUM_CH-1:0] out_en,
   output logic [NUM_CH-1:0] pd_status,
   output logic              busy
);

   ch_state_e         st [NUM_CH];
   logic [NUM_CH-1:0] is_off;
   logic [NUM_CH-1:0] is_settle;
   logic [NUM_CH-1:0] eligible;
   logic [NUM_CH-1:0] grant;
   logic              start;
   logic              settle_done;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("chan_pwr_seq: NUM_CH must be at least 1");
      end
   endgenerate

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         pwr_seq_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .grant      (grant[g]),
            .settle_done(settle_done),
            .state      (st[g]),
            .core_en    (core_en[g]),
            .boost_en   (boost_en[g]),
            .out_en     (out_en[g])
         );
         assign is_off[g]    = (st[g] == CH_OFF);
         assign is_settle[g] = (st[g] == CH_SETTLE);
      end
   endgenerate

   assign busy = |is_settle;

   // While settling, only the settling channel's abort may be served.
   always_comb begin
      if (busy)
         eligible = pd_req & is_settle;
      else
         eligible = (~pd_req & is_off) | (pd_req & ~is_off);
   end

   pwr_seq_arb #(.NUM_CH(NUM_CH)) u_arb (
      .eligible(eligible),
      .grant   (grant)
   );

   assign start = |(grant & is_off);

   pwr_seq_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .run    (busy),
      .us_tick(us_tick),
      .done   (settle_done)
   );

   assign pd_status = is_off;

   // R6
   one_settling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(is_settle));

   generate
      for (genvar a = 0; a < NUM_CH; a++) begin : g_chk
         // R7
         others_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && !is_settle[a]) |=> ($stable(pd_status[a]) && $stable(out_en[a])));

         // R8
         abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_settle[a] && pd_req[a]) |=> (!core_en[a] && !boost_en[a] && !out_en[a]));

         // R3
         out_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_en[a]) |-> $past(us_tick));
      end
   endgenerate

endmodule

// File: tb/test_chan_pwr_seq.sv
`timescale 1ns/1ps
module test_chan_pwr_seq;

   localparam int N  = 4;
   localparam int ST = 200;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pd_req = '1;
   logic         us_tick = 1'b0;
   logic [N-1:0] core_en, boost_en, out_en, pd_status;
   logic         busy;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   chan_pwr_seq #(.NUM_CH(N), .SETTLE_TICKS(ST)) i_chan_pwr_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pd_req   (pd_req),
      .us_tick  (us_tick),
      .core_en  (core_en),
      .boost_en (boost_en),
      .out_en   (out_en),
      .pd_status(pd_status),
      .busy     (busy)
   );

   task automatic cyc(input logic t);
      us_tick = t;
      @(negedge clk);
      us_tick = 1'b0;
   endtask

   task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: act core/boost/out/stat/busy=%b expected %b", req, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input logic [N-1:0] c, input logic [N-1:0] o,
                          input logic [N-1:0] s, input logic b);
      chk(req, {core_en, boost_en, out_en, pd_status, busy}, {c, c, o, s, b});
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) cyc(1'b0);
      rst_n = 1'b1;
      cyc(1'b0);
      chk_all("R1 reset state", 4'b0000, 4'b0000, 4'b1111, 1'b0);
   endtask

   task automatic t_powerup;
      pd_req = 4'b1110;
      cyc(1'b1);                      // tick on starting edge is ignored
      chk_all("R2 phase one", 4'b0001, 4'b0000, 4'b1110, 1'b1);
      repeat (5) cyc(1'b0);
      chk_all("R3 no tick no progress", 4'b0001, 4'b0000, 4'b1110, 1'b1);
      for (int k = 0; k < ST; k++) cyc(1'b1);
      chk_all("R3 not yet after SETTLE_TICKS", 4'b0001, 4'b0000, 4'b1110, 1'b1);
      cyc(1'b1);
      chk_all("R3 out on final tick", 4'b0001, 4'b0001, 4'b1110, 1'b0);
   endtask

   task automatic t_match;
      repeat (6) cyc(1'b1);
      chk_all("R5 matching requests idle", 4'b0001, 4'b0001, 4'b1110, 1'b0);
   endtask

   task automatic t_powerdown;
      pd_req = 4'b1111;
      cyc(1'b0);
      chk_all("R4 single-step down", 4'b0000, 4'b0000, 4'b1111, 1'b0);
      repeat (4) cyc(1'b0);
      chk_all("R5 off stays off", 4'b0000, 4'b0000, 4'b1111, 1'b0);
   endtask

   task automatic t_order;
      pd_req = 4'b0000;
      cyc(1'b0);
      chk_all("R6 lowest first", 4'b0001, 4'b0000, 4'b1110, 1'b1);
      for (int k = 0; k <= ST; k++) cyc(1'b1);
      chk_all("R6 ch0 on, ch1 waits", 4'b0001, 4'b0001, 4'b1110, 1'b0);
      cyc(1'b0);
      chk_all("R6 ch1 next", 4'b0011, 4'b0001, 4'b1100, 1'b1);
   endtask

   task automatic t_block_abort;
      pd_req = 4'b0001;
      repeat (3) cyc(1'b1);
      chk_all("R7 ch0 down held while busy", 4'b0011, 4'b0001, 4'b1100, 1'b1);
      pd_req = 4'b0011;
      cyc(1'b0);
      chk_all("R8 abort ch1", 4'b0001, 4'b0001, 4'b1110, 1'b0);
      cyc(1'b0);
      chk_all("R7 ch0 down after settle ends", 4'b0000, 4'b0000, 4'b1111, 1'b0);
      cyc(1'b0);
      chk_all("R6 ch2 next", 4'b0100, 4'b0000, 4'b1011, 1'b1);
      repeat (50) cyc(1'b1);
      pd_req = 4'b1111;
      cyc(1'b1);
      chk_all("R8 abort mid-count", 4'b0000, 4'b0000, 4'b1111, 1'b0);
   endtask

   task automatic t_tick_gap;
      repeat (20) cyc(1'b1);          // idle ticks must not count
      pd_req = 4'b0111;
      cyc(1'b1);
      chk_all("R9 settling not powered down", 4'b1000, 4'b0000, 4'b0111, 1'b1);
      for (int k = 0; k < ST; k++) begin
         cyc(1'b1);
         if (k % 37 == 0) cyc(1'b0);
      end
      chk_all("R3 gaps keep count", 4'b1000, 4'b0000, 4'b0111, 1'b1);
      cyc(1'b1);
      chk_all("R9 on clears status", 4'b1000, 4'b1000, 4'b0111, 1'b0);
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog: act timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_powerup();
      t_match();
      t_powerdown();
      t_order();
      t_block_abort();
      t_tick_gap();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule